// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block turns a 32-bit virtual address into a physical address through a small translation buffer searched in full in a single cycle. Every entry is tagged with an address-space number as well as a virtual page number. Entries that belong to several processes can therefore stay resident together, and a context switch needs no flush. The lookup path is combinational. It returns the physical address, a hit flag, a 2-bit fault code, a cacheability flag and the dirty and referenced bits of the selected entry.

Software fills the buffer through a write port. The target slot is either an explicit index or the current value of a victim counter, which stands in for random replacement. A low band of wired slots is never offered as a victim. A separate port drops one slot or every slot. The top three address bits select the segment. Two segments bypass the buffer entirely. A user-mode access to any kernel segment is refused.

The block has no state machine. Its state is the entry table, the victim counter and a sticky flag that reports multiple matches.

Top module: `tlb_asid_xlate`

## Requirements
- R1: A lookup in a mapped segment that matches a present entry on both page number (address bits 31..12) and address-space number, where that entry's valid bit is set, gives lk_hit=1 and lk_fault=0. On a read, or on a write to an entry marked writable, lk_paddr is the entry's physical page followed by the unchanged 12-bit offset. lk_dirty and lk_ref show the entry's bits.
- R2: A mapped lookup that matches no present entry, or whose selected entry has its valid bit clear, gives lk_fault=1 (refill), lk_hit=0 and lk_paddr=0.
- R3: A write access (lk_write=1) whose selected entry is valid but not writable (rw=0) gives lk_fault=2 (protection), lk_hit=1 and lk_paddr=0.
- R4: Segment decode uses address bits 31..29:
  - 0xx is user space, mapped.
  - 11x is kernel space, mapped.
  - 100 is kernel space, unmapped and cached.
  - 101 is kernel space, unmapped and uncached.

  An unmapped lookup gives lk_hit=0, lk_fault=0 and lk_paddr equal to the address with its top three bits cleared. lk_cached is 0 only for pattern 101.
- R5: When lk_user=1 and address bit 31 is 1, lk_fault=3 (address error) and lk_hit=0. This takes priority over every other outcome.
- R6: When several present entries match, the lowest index supplies the translation. multi_flag is set at the next clock edge and then holds. Only reset or inv_all clears it.
- R7: victim_idx is ENTRIES-1 (63) in reset and decrements by one each clock. After it reaches WIRED (8) it reloads ENTRIES-1, so it never goes below WIRED.
- R8: With wr_en=1, the entry is written at the clock edge. The target is wr_index when wr_random=0, or the victim_idx value held before that edge when wr_random=1. The new contents are visible to lookups from the next cycle on.
- R9: inv_one removes the entry at inv_index. inv_all removes every entry. Removal wins over a write to the same slot in the same cycle, and other slots are unaffected.
- R10: After reset every slot is empty, so every mapped lookup gives a refill fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 6 | Current address-space number |
| lk_user | input | 1 | 1 = user mode |
| lk_write | input | 1 | 1 = write access |
| lk_paddr | output | 32 | Physical address, 0 on a fault |
| lk_hit | output | 1 | Valid buffer entry selected |
| lk_fault | output | 2 | 0 none, 1 refill, 2 protection, 3 address error |
| lk_cached | output | 1 | Access may be cached |
| lk_dirty | output | 1 | Dirty bit of the selected entry |
| lk_ref | output | 1 | Referenced bit of the selected entry |
| multi_flag | output | 1 | Sticky multiple-match flag |
| victim_idx | output | 6 | Current replacement candidate |
| wr_en | input | 1 | Write an entry |
| wr_random | input | 1 | Use victim_idx as the target |
| wr_index | input | 6 | Explicit target slot |
| wr_vpn | input | 20 | Virtual page number |
| wr_asid | input | 6 | Address-space number |
| wr_ppn | input | 20 | Physical page number |
| wr_dirty | input | 1 | Dirty bit |
| wr_ref | input | 1 | Referenced bit |
| wr_valid | input | 1 | Valid bit |
| wr_rw | input | 1 | 1 = writable, 0 = read-only |
| inv_one | input | 1 | Remove one slot |
| inv_index | input | 6 | Slot to remove |
| inv_all | input | 1 | Remove every slot |

## Verification
The hardest situation to reach from the ports is proving where random writes land, because the victim index advances every cycle and is never directly written.

The stimulus first fills the wired band explicitly. It then issues random writes on back-to-back cycles, recording victim_idx before each edge. Lookups afterwards confirm three things:
- the last 56 writes all survive, which shows the victims were distinct;
- the earliest writes were overwritten;
- every wired slot is untouched.

Duplicate matches are created deliberately by writing the same key into two slots. This exercises the lowest-index priority and the sticky flag.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W      = 32;
    localparam int PAGE_BITS = 12;
    localparam int VPN_W     = VA_W - PAGE_BITS;
    localparam int PPN_W     = 20;
    localparam int ASID_W    = 6;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_REFILL = 2'd1,
        FLT_PROT   = 2'd2,
        FLT_ADDR   = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        SEG_USER_MAP,
        SEG_KERN_CACHED,
        SEG_KERN_UNCACHED,
        SEG_KERN_MAP
    } seg_e;

    typedef struct packed {
        logic              present;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
        logic              dirty;
        logic              refd;
        logic              valid;
        logic              rw;
    } entry_t;
endpackage

// File: rtl/tlb_seg_decode.sv
module tlb_seg_decode
    import tlb_pkg::*;
(
    input  logic [2:0] top_bits,
    output logic       mapped,
    output logic       cached
);
    seg_e seg;

    always_comb begin
        unique casez (top_bits)
            3'b0??:  seg = SEG_USER_MAP;
            3'b100:  seg = SEG_KERN_CACHED;
            3'b101:  seg = SEG_KERN_UNCACHED;
            default: seg = SEG_KERN_MAP;
        endcase
    end

    assign mapped = (seg == SEG_USER_MAP) || (seg == SEG_KERN_MAP);
    assign cached = (seg != SEG_KERN_UNCACHED);
endmodule

// File: rtl/tlb_victim_ctr.sv
module tlb_victim_ctr #(
    parameter  int ENTRIES = 64,
    parameter  int WIRED   = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] victim
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(ENTRIES - 1);
    localparam logic [IDX_W-1:0] LOW_IDX = IDX_W'(WIRED);

    always_ff @(posedge clk) begin
        if (!rst_n)               victim <= TOP_IDX;
        else if (victim <= LOW_IDX) victim <= TOP_IDX;
        else                      victim <= victim - 1'b1;
    end
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter  int ENTRIES = 64,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  entry_t            wr_data,
    input  logic              inv_one,
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic              inv_all,
    input  logic [VPN_W-1:0]  key_vpn,
    input  logic [ASID_W-1:0] key_asid,
    output logic              any_match,
    output logic              multi_match,
    output logic [PPN_W-1:0]  sel_ppn,
    output logic              sel_dirty,
    output logic              sel_ref,
    output logic              sel_valid,
    output logic              sel_rw
);
    entry_t             tbl [ENTRIES];
    logic [ENTRIES-1:0] match;

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n)
                tbl[i] <= '0;
            else if (inv_all || (inv_one && inv_idx == IDX_W'(i)))
                tbl[i].present <= 1'b0;
            else if (wr_en && wr_idx == IDX_W'(i))
                tbl[i] <= wr_data;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = tbl[g].present && (tbl[g].vpn == key_vpn)
                          && (tbl[g].asid == key_asid);
    end

    always_comb begin
        any_match   = 1'b0;
        multi_match = 1'b0;
        sel_ppn     = '0;
        sel_dirty   = 1'b0;
        sel_ref     = 1'b0;
        sel_valid   = 1'b0;
        sel_rw      = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                if (any_match) begin
                    multi_match = 1'b1;
                end else begin
                    sel_ppn   = tbl[i].ppn;
                    sel_dirty = tbl[i].dirty;
                    sel_ref   = tbl[i].refd;
                    sel_valid = tbl[i].valid;
                    sel_rw    = tbl[i].rw;
                end
                any_match = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlb_asid_xlate.sv
module tlb_asid_xlate
    import tlb_pkg::*;
#(
    parameter  int ENTRIES = 64,
    parameter  int WIRED   = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_user,
    input  logic              lk_write,
    output logic [VA_W-1:0]   lk_paddr,
    output logic              lk_hit,
    output logic [1:0]        lk_fault,
    output logic              lk_cached,
    output logic              lk_dirty,
    output logic              lk_ref,
    output logic              multi_flag,
    output logic [IDX_W-1:0]  victim_idx,
    input  logic              wr_en,
    input  logic              wr_random,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic              wr_dirty,
    input  logic              wr_ref,
    input  logic              wr_valid,
    input  logic              wr_rw,
    input  logic              inv_one,
    input  logic [IDX_W-1:0]  inv_index,
    input  logic              inv_all
);
    logic             mapped;
    logic             addr_err;
    logic             any_match, multi_match;
    logic [PPN_W-1:0] sel_ppn;
    logic             sel_dirty, sel_ref, sel_valid, sel_rw;
    logic [IDX_W-1:0] wr_target;
    entry_t           wr_data;
    fault_e           flt;

    tlb_seg_decode u_seg (
        .top_bits (lk_vaddr[VA_W-1 -: 3]),
        .mapped   (mapped),
        .cached   (lk_cached)
    );

    tlb_victim_ctr #(.ENTRIES(ENTRIES), .WIRED(WIRED)) u_victim (
        .clk    (clk),
        .rst_n  (rst_n),
        .victim (victim_idx)
    );

    assign wr_target = wr_random ? victim_idx : wr_index;
    assign wr_data   = '{present: 1'b1, vpn: wr_vpn, asid: wr_asid, ppn: wr_ppn,
                         dirty: wr_dirty, refd: wr_ref, valid: wr_valid, rw: wr_rw};

    tlb_entry_array #(.ENTRIES(ENTRIES)) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (wr_target),
        .wr_data     (wr_data),
        .inv_one     (inv_one),
        .inv_idx     (inv_index),
        .inv_all     (inv_all),
        .key_vpn     (lk_vaddr[VA_W-1:PAGE_BITS]),
        .key_asid    (lk_asid),
        .any_match   (any_match),
        .multi_match (multi_match),
        .sel_ppn     (sel_ppn),
        .sel_dirty   (sel_dirty),
        .sel_ref     (sel_ref),
        .sel_valid   (sel_valid),
        .sel_rw      (sel_rw)
    );

    assign addr_err = lk_user && lk_vaddr[VA_W-1];

    always_comb begin
        flt      = FLT_NONE;
        lk_hit   = 1'b0;
        lk_paddr = '0;
        lk_dirty = 1'b0;
        lk_ref   = 1'b0;
        if (addr_err) begin
            flt = FLT_ADDR;
        end else if (!mapped) begin
            lk_paddr = {3'b000, lk_vaddr[VA_W-4:0]};
        end else if (!any_match || !sel_valid) begin
            flt = FLT_REFILL;
        end else begin
            lk_hit   = 1'b1;
            lk_dirty = sel_dirty;
            lk_ref   = sel_ref;
            if (lk_write && !sel_rw) flt = FLT_PROT;
            else lk_paddr = {sel_ppn, lk_vaddr[PAGE_BITS-1:0]};
        end
    end

    assign lk_fault = flt;

    always_ff @(posedge clk) begin
        if (!rst_n)                                      multi_flag <= 1'b0;
        else if (inv_all)                                multi_flag <= 1'b0;
        else if (!addr_err && mapped && multi_match)     multi_flag <= 1'b1;
    end
endmodule

// File: rtl/tlb_asid_xlate_chk.sv
module tlb_asid_xlate_chk
    import tlb_pkg::*;
#(
    parameter  int ENTRIES = 64,
    parameter  int WIRED   = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [VA_W-1:0]  lk_vaddr,
    input logic             lk_user,
    input logic             lk_write,
    input logic [VA_W-1:0]  lk_paddr,
    input logic             lk_hit,
    input logic [1:0]       lk_fault,
    input logic             lk_cached,
    input logic             multi_flag,
    input logic [IDX_W-1:0] victim_idx,
    input logic             inv_all
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(ENTRIES - 1);
    localparam logic [IDX_W-1:0] LOW_IDX = IDX_W'(WIRED);

    assert_hit_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_fault == FLT_NONE || lk_fault == FLT_PROT));

    assert_offset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_fault == FLT_NONE) |-> lk_paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]);

    assert_refill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_fault == FLT_REFILL) |-> (!lk_hit && lk_paddr == '0));

    assert_prot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_fault == FLT_PROT) |-> (lk_write && lk_hit && lk_paddr == '0));

    assert_unmapped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_user && lk_vaddr[VA_W-1 -: 2] == 2'b10)
        |-> (lk_fault == FLT_NONE && !lk_hit && lk_cached == !lk_vaddr[VA_W-3]));

    assert_addr_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_user && lk_vaddr[VA_W-1]) |-> (lk_fault == FLT_ADDR && !lk_hit));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (multi_flag && !inv_all) |=> multi_flag);

    assert_victim_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        victim_idx >= LOW_IDX);

    assert_victim_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> victim_idx == (($past(victim_idx) == LOW_IDX) ? TOP_IDX
                                                              : $past(victim_idx) - 1'b1));

    assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (!lk_hit && !multi_flag));
endmodule

bind tlb_asid_xlate tlb_asid_xlate_chk #(.ENTRIES(ENTRIES), .WIRED(WIRED)) u_chk (.*);

// File: tb/tlb_asid_xlate_test.sv
module tlb_asid_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [5:0]  lk_asid = '0;
    logic        lk_user = 1'b1, lk_write = 1'b0;
    logic [31:0] lk_paddr;
    logic        lk_hit, lk_cached, lk_dirty, lk_ref, multi_flag;
    logic [1:0]  lk_fault;
    logic [5:0]  victim_idx;
    logic        wr_en = 1'b0, wr_random = 1'b0;
    logic [5:0]  wr_index = '0, wr_asid = '0, inv_index = '0;
    logic [19:0] wr_vpn = '0, wr_ppn = '0;
    logic        wr_dirty = 1'b0, wr_ref = 1'b0, wr_valid = 1'b0, wr_rw = 1'b0;
    logic        inv_one = 1'b0, inv_all = 1'b0;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tlb_asid_xlate uut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] va, input logic [5:0] asid, input logic usr, input logic wr);
        @(negedge clk);
        lk_vaddr = va; lk_asid = asid; lk_user = usr; lk_write = wr;
        #1;
    endtask

    task automatic put(input logic [5:0] idx, input logic [19:0] vpn, input logic [5:0] asid,
                       input logic [19:0] ppn, input logic d, input logic r, input logic v, input logic rw);
        @(negedge clk);
        wr_en = 1; wr_random = 0; wr_index = idx; wr_vpn = vpn; wr_asid = asid;
        wr_ppn = ppn; wr_dirty = d; wr_ref = r; wr_valid = v; wr_rw = rw;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic drop_one(input logic [5:0] idx);
        @(negedge clk); inv_one = 1; inv_index = idx;
        @(negedge clk); inv_one = 0;
    endtask

    task automatic drop_all();
        @(negedge clk); inv_all = 1;
        @(negedge clk); inv_all = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [5:0] vic [60];
        logic [5:0] prev;
        int wraps;

        // R10: reset state
        look(32'h0010_0123, 6'd0, 1'b1, 1'b0);
        @(negedge clk); @(negedge clk);
        chk("R10 fault in reset", lk_fault, 2'd1);
        chk("R10 hit in reset", lk_hit, 1'b0);
        chk("R7 victim reset", victim_idx, 6'd63);
        chk("R6 sticky reset", multi_flag, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 first step", victim_idx, 6'd62);
        look(32'h0010_0123, 6'd0, 1'b1, 1'b0);
        chk("R10 empty after reset", lk_fault, 2'd1);

        // R8: fill every slot by explicit index
        for (int i = 0; i < 64; i++)
            put(6'(i), 20'h00100 + 20'(i), 6'(i) ^ 6'h2A, 20'h50000 + 20'(i * 3),
                i[1], i[2], (i % 5) != 0, i[0]);

        // R1 R2 R3: sweep all slots
        for (int i = 0; i < 64; i++) begin
            logic [19:0] vpn; logic [11:0] off; logic [19:0] ppn; logic [5:0] as; bit v;
            vpn = 20'h00100 + 20'(i); off = 12'(i * 37 + 5); ppn = 20'h50000 + 20'(i * 3);
            as = 6'(i) ^ 6'h2A; v = (i % 5) != 0;
            look({vpn, off}, as, 1'b1, 1'b0);
            if (v) begin
                chk("R1 read hit", lk_hit, 1'b1);
                chk("R1 read paddr", lk_paddr, {ppn, off});
                chk("R1 dirty/ref", {lk_dirty, lk_ref}, {i[1], i[2]});
                chk("R1 fault none", lk_fault, 2'd0);
            end else begin
                chk("R2 valid clear refill", lk_fault, 2'd1);
                chk("R2 paddr zero", {lk_hit, lk_paddr}, 33'd0);
            end
            look({vpn, off}, as, 1'b1, 1'b1);
            if (v && !i[0]) begin
                chk("R3 prot fault", lk_fault, 2'd2);
                chk("R3 prot hit/paddr", {lk_hit, lk_paddr}, {1'b1, 32'd0});
            end else if (v) begin
                chk("R1 write hit paddr", lk_paddr, {ppn, off});
            end
            look({vpn, off}, as ^ 6'h01, 1'b1, 1'b0);
            chk("R2 asid mismatch refill", lk_fault, 2'd1);
        end

        // R4 segments
        look(32'h8001_2345, 6'd0, 1'b0, 1'b0);
        chk("R4 kseg cached paddr", lk_paddr, 32'h0001_2345);
        chk("R4 kseg cached flags", {lk_hit, lk_fault, lk_cached}, 4'b0001);
        look(32'hA765_4321, 6'd0, 1'b0, 1'b1);
        chk("R4 kseg uncached paddr", lk_paddr, 32'h0765_4321);
        chk("R4 kseg uncached flags", {lk_hit, lk_fault, lk_cached}, 4'b0000);
        put(6'd3, 20'hC0010, 6'd5, 20'h12345, 1'b0, 1'b0, 1'b1, 1'b1);
        look(32'hC001_0ABC, 6'd5, 1'b0, 1'b0);
        chk("R4 mapped kernel paddr", lk_paddr, 32'h1234_5ABC);
        look(32'hE001_0ABC, 6'd5, 1'b0, 1'b0);
        chk("R4 mapped kernel miss", lk_fault, 2'd1);
        // R5 address error
        look(32'hC001_0ABC, 6'd5, 1'b1, 1'b0);
        chk("R5 user on mapped kernel", {lk_fault, lk_hit}, 3'b110);
        look(32'h8000_0000, 6'd0, 1'b1, 1'b0);
        chk("R5 user on unmapped", {lk_fault, lk_paddr}, {2'd3, 32'd0});

        // R9: single invalidate
        drop_one(6'd6);
        look({20'h00106, 12'h010}, 6'd6 ^ 6'h2A, 1'b1, 1'b0);
        chk("R9 dropped slot refills", lk_fault, 2'd1);
        look({20'h00107, 12'h010}, 6'd7 ^ 6'h2A, 1'b1, 1'b0);
        chk("R9 neighbour kept", lk_paddr, {20'h50015, 12'h010});
        // R9: invalidate beats write, same cycle
        @(negedge clk);
        wr_en = 1; wr_index = 6'd30; wr_vpn = 20'h09000; wr_asid = 6'd2; wr_ppn = 20'h0F000;
        wr_valid = 1; wr_rw = 1; inv_one = 1; inv_index = 6'd30;
        @(negedge clk); wr_en = 0; inv_one = 0;
        look(32'h0900_0004, 6'd2, 1'b1, 1'b0);
        chk("R9 invalidate wins", lk_fault, 2'd1);

        // R6 multiple match
        look(32'h0010_1000, 6'd1 ^ 6'h2A, 1'b1, 1'b0);
        @(negedge clk);
        chk("R6 sticky clear before dup", multi_flag, 1'b0);
        put(6'd20, 20'h07000, 6'd9, 20'hBBBBB, 1'b0, 1'b0, 1'b1, 1'b1);
        put(6'd10, 20'h07000, 6'd9, 20'hAAAAA, 1'b0, 1'b0, 1'b1, 1'b1);
        look(32'h0700_0123, 6'd9, 1'b1, 1'b0);
        chk("R6 lowest index wins", lk_paddr, 32'hAAAA_A123);
        look(32'h0010_1000, 6'd1 ^ 6'h2A, 1'b1, 1'b0);
        chk("R6 sticky set", multi_flag, 1'b1);
        drop_one(6'd10);
        look(32'h0700_0123, 6'd9, 1'b1, 1'b0);
        chk("R6 next match after drop", lk_paddr, 32'hBBBB_B123);
        chk("R6 sticky holds", multi_flag, 1'b1);
        drop_all();
        chk("R6 sticky cleared by flush", multi_flag, 1'b0);
        look(32'h0700_0123, 6'd9, 1'b1, 1'b0);
        chk("R9 flush removes all", lk_fault, 2'd1);
        look({20'h00101, 12'h0}, 6'd1 ^ 6'h2A, 1'b1, 1'b0);
        chk("R9 flush removes sweep entry", lk_fault, 2'd1);

        // R7 victim sequence
        wraps = 0;
        @(negedge clk); prev = victim_idx;
        for (int k = 0; k < 130; k++) begin
            @(negedge clk);
            if (victim_idx == 6'd63) wraps++;
            if (victim_idx !== ((prev == 6'd8) ? 6'd63 : prev - 6'd1) || victim_idx < 6'd8)
                chk("R7 victim step", victim_idx, (prev == 6'd8) ? 6'd63 : prev - 6'd1);
            prev = victim_idx;
        end
        chk("R7 victim wraps", wraps >= 2, 1'b1);

        // R8 random writes versus wired slots
        for (int i = 0; i < 8; i++)
            put(6'(i), 20'h02000 + 20'(i), 6'd1, 20'h00400 + 20'(i), 1'b0, 1'b0, 1'b1, 1'b1);
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            vic[k] = victim_idx;
            wr_en = 1; wr_random = 1; wr_index = 6'd0; wr_vpn = 20'h03000 + 20'(k);
            wr_asid = 6'd1; wr_ppn = 20'h00600 + 20'(k); wr_valid = 1; wr_rw = 1;
        end
        @(negedge clk); wr_en = 0; wr_random = 0;
        for (int k = 0; k < 60; k++) begin
            if (vic[k] < 6'd8) chk("R7 victim below wired", vic[k], 6'd8);
            look({20'h03000 + 20'(k), 12'h07F}, 6'd1, 1'b1, 1'b0);
            if (k >= 4) chk("R8 random write lands", lk_paddr, {20'h00600 + 20'(k), 12'h07F});
            else        chk("R8 oldest random overwritten", lk_fault, 2'd1);
        end
        for (int i = 0; i < 8; i++) begin
            look({20'h02000 + 20'(i), 12'h001}, 6'd1, 1'b1, 1'b0);
            chk("R7 wired slot untouched", lk_paddr, {20'h00400 + 20'(i), 12'h001});
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule